// File: doc/BRIEF.md
# UART Transmit and Receive Byte Queues with Watermarks

This block holds the byte queues that sit between a UART's register bus and its serial shifters. Software writes transmit bytes and reads received bytes through one data address; the transmit shifter drains the transmit queue through a valid/pop pair and the receive shifter fills the receive queue through a push strobe. Each direction can run as a deep queue or fall back to a one-entry holding buffer. The depth of each queue is fixed by a 3-bit size code parameter, and the depth is 2^(code+1) entries.

Software sets a watermark for each direction. The transmit request tells the host that there is room to refill, and the receive request tells it that enough data waits to be collected. Writes to a full transmit queue, bytes arriving at a full receive queue and reads of an empty receive queue each leave a sticky flag. Each flag can be routed to an error request, and software clears the flags by writing ones. Self-clearing flush bits empty either queue without touching those flags.

Register map on the 3-bit address: 0 size/enable, 1 control, 2 status, 3 transmit watermark, 4 transmit count, 5 receive watermark, 6 receive count, 7 data. The reset input is asynchronous and its release is synchronised inside the block, so the first register access may come two cycles after `rst_n` rises. The size codes must not exceed 6.

Top module: `uart_fifo_regs`

## Requirements
- R1: Address 0 reads the transmit size code in bits [6:4], the receive size code in bits [2:0], the transmit queue-mode enable in bit 7 and the receive queue-mode enable in bit 3. Only bits 7 and 3 are writable, both reset to 0, and bits 8'h21 read back after reset with the default codes (2 and 1).
- R2: With its enable at 0 a direction holds at most one byte, and a second transmit write is dropped and raises the transmit overflow flag.
- R3: With its enable at 1 the transmit queue accepts 2^(code+1) bytes. The next write is dropped, the count is unchanged and status bit 1 (transmit overflow) is set.
- R4: Address 4 reads the number of bytes in the transmit queue and address 6 the number in the receive queue.
- R5: Writing 1 to control bit 7 empties the transmit queue and writing 1 to bit 6 empties the receive queue within one cycle. Both bits read back as 0, and a flush leaves the sticky flags unchanged.
- R6: `tx_req` is high exactly while the transmit count is less than or equal to the transmit watermark (address 3).
- R7: `rx_req` is high exactly while the receive count is greater than the receive watermark (address 5).
- R8: A `rx_push` into a full receive queue drops the byte and sets status bit 2 (receive overflow). Accepted bytes are read back from address 7 in arrival order.
- R9: Reading address 7 while the receive queue is empty returns the last byte read and sets status bit 0 (receive underflow).
- R10: Status bit 7 is high while the transmit queue is empty and bit 6 while the receive queue is empty. Writing 1 to status bits 2..0 clears the matching flag, and writing 0 leaves it set.
- R11: `err_req` is high while any flag in status bits 2..0 is set and its enable in the same bit of control register bits 2..0 is 1.
- R12: `tx_valid` is high while the transmit queue holds data and `tx_byte` shows the oldest byte. A `tx_pop` removes it, so bytes leave in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 7) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of the read |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_pop | input | 1 | Transmit shifter takes the oldest byte |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_byte | input | 8 | Received byte |
| tx_req | output | 1 | Transmit refill request |
| rx_req | output | 1 | Receive collect request |
| err_req | output | 1 | Enabled error flag pending |

## Verification
The bench fills the transmit queue exactly to its depth and one past it. An off-by-one capacity would show either a count of 9 or a dropped eighth byte with no flag. It reads the receive queue past empty to catch a design that returns stale memory or forgets the underflow flag. It flushes while a flag is set to catch logic that ties the flag clear to the pointer reset. It walks both watermark comparisons across their threshold, where a swapped `<` or `<=` moves the request edge by one byte. It also sets the byte-mode enable back to single and confirms that a second write is refused.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef enum logic [2:0] {
    A_SIZE   = 3'd0,
    A_CTRL   = 3'd1,
    A_STAT   = 3'd2,
    A_TXMARK = 3'd3,
    A_TXCNT  = 3'd4,
    A_RXMARK = 3'd5,
    A_RXCNT  = 3'd6,
    A_DATA   = 3'd7
  } reg_addr_e;

  // size/enable register
  localparam int B_TXEN = 7;
  localparam int B_RXEN = 3;
  // control register
  localparam int B_TXFLUSH = 7;
  localparam int B_RXFLUSH = 6;
  // status register
  localparam int B_TXEMPTY = 7;
  localparam int B_RXEMPTY = 6;
  localparam int B_RXOVF   = 2;
  localparam int B_TXOVF   = 1;
  localparam int B_RXUNF   = 0;

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter  int DEPTH_CODE = 2,
  parameter  int W          = 8,
  localparam int CW         = DEPTH_CODE + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          single,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [W-1:0]  last,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          push_drop,
  output logic          pop_miss
);

  localparam int DEPTH = 2 ** (DEPTH_CODE + 1);
  localparam int AW    = DEPTH_CODE + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW-1:0] rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  last_q;
  logic [CW-1:0] cap;
  logic          push_ok, pop_ok;
  logic          ptr_en;

  assign cap     = single ? CW'(1) : CW'(DEPTH);
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q >= cap);
  assign push_ok = push & ~full  & ~flush;
  assign pop_ok  = pop  & ~empty & ~flush;
  assign push_drop = push & full  & ~flush;
  assign pop_miss  = pop  & empty & ~flush;
  assign ptr_en  = flush | push_ok | pop_ok;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push_ok) wptr_d = wptr_q + AW'(1);
      if (pop_ok)  rptr_d = rptr_q + AW'(1);
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (ptr_en) begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
    end else if (pop_ok) begin
      last_q <= mem[rptr_q];
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= push_data;
  end

  assign head  = mem[rptr_q];
  assign last  = last_q;
  assign count = cnt_q;

endmodule

// File: rtl/uart_fifo_csr.sv
module uart_fifo_csr
  import uart_fifo_pkg::*;
#(
  parameter int TX_DEPTH_CODE = 2,
  parameter int RX_DEPTH_CODE = 1,
  parameter int TX_CW         = TX_DEPTH_CODE + 2,
  parameter int RX_CW         = RX_DEPTH_CODE + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [TX_CW-1:0] tx_count,
  input  logic [RX_CW-1:0] rx_count,
  input  logic             tx_empty,
  input  logic             rx_empty,
  input  logic [7:0]       rx_head,
  input  logic [7:0]       rx_last,
  input  logic             tx_drop,
  input  logic             rx_drop,
  input  logic             rx_miss,
  output logic             tx_flush,
  output logic             rx_flush,
  output logic             tx_push,
  output logic             rx_pop,
  output logic             tx_fifo_en,
  output logic             rx_fifo_en,
  output logic [2:0]       stat_q,
  output logic             tx_req,
  output logic             rx_req,
  output logic             err_req
);

  logic       wr_size, wr_ctrl, wr_stat, wr_txm, wr_rxm;
  logic [1:0] en_q, en_d;
  logic [2:0] err_en_q, err_en_d;
  logic [7:0] txm_q, txm_d;
  logic [7:0] rxm_q, rxm_d;
  logic [2:0] stat_d, flag_set, flag_clr;
  logic       stat_en;
  logic [7:0] tx_cnt8, rx_cnt8;

  assign wr_size = reg_wr & (reg_addr == A_SIZE);
  assign wr_ctrl = reg_wr & (reg_addr == A_CTRL);
  assign wr_stat = reg_wr & (reg_addr == A_STAT);
  assign wr_txm  = reg_wr & (reg_addr == A_TXMARK);
  assign wr_rxm  = reg_wr & (reg_addr == A_RXMARK);

  assign tx_flush = wr_ctrl & reg_wdata[B_TXFLUSH];
  assign rx_flush = wr_ctrl & reg_wdata[B_RXFLUSH];
  assign tx_push  = reg_wr & (reg_addr == A_DATA);
  assign rx_pop   = reg_rd & (reg_addr == A_DATA);

  // next-state
  always_comb begin
    en_d     = {reg_wdata[B_TXEN], reg_wdata[B_RXEN]};
    err_en_d = reg_wdata[2:0];
    txm_d    = reg_wdata;
    rxm_d    = reg_wdata;
    flag_set = '0;
    flag_set[B_RXOVF] = rx_drop;
    flag_set[B_TXOVF] = tx_drop;
    flag_set[B_RXUNF] = rx_miss;
    flag_clr = wr_stat ? reg_wdata[2:0] : 3'b000;
    stat_d   = (stat_q & ~flag_clr) | flag_set;
    stat_en  = wr_stat | (|flag_set);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_size) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_en_q <= '0;
    end else if (wr_ctrl) begin
      err_en_q <= err_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txm_q <= '0;
    end else if (wr_txm) begin
      txm_q <= txm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxm_q <= '0;
    end else if (wr_rxm) begin
      rxm_q <= rxm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  assign tx_fifo_en = en_q[1];
  assign rx_fifo_en = en_q[0];
  assign tx_cnt8    = 8'(tx_count);
  assign rx_cnt8    = 8'(rx_count);

  assign tx_req  = (tx_cnt8 <= txm_q);
  assign rx_req  = (rx_cnt8 >  rxm_q);
  assign err_req = |(stat_q & err_en_q);

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SIZE: begin
        reg_rdata[B_TXEN] = en_q[1];
        reg_rdata[6:4]    = 3'(TX_DEPTH_CODE);
        reg_rdata[B_RXEN] = en_q[0];
        reg_rdata[2:0]    = 3'(RX_DEPTH_CODE);
      end
      A_CTRL:   reg_rdata[2:0] = err_en_q;
      A_STAT: begin
        reg_rdata[B_TXEMPTY] = tx_empty;
        reg_rdata[B_RXEMPTY] = rx_empty;
        reg_rdata[2:0]       = stat_q;
      end
      A_TXMARK: reg_rdata = txm_q;
      A_TXCNT:  reg_rdata = tx_cnt8;
      A_RXMARK: reg_rdata = rxm_q;
      A_RXCNT:  reg_rdata = rx_cnt8;
      A_DATA:   reg_rdata = rx_empty ? rx_last : rx_head;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_fifo_regs.sv
module uart_fifo_regs #(
  parameter  int TX_DEPTH_CODE = 2,
  parameter  int RX_DEPTH_CODE = 1,
  localparam int TX_CW         = TX_DEPTH_CODE + 2,
  localparam int RX_CW         = RX_DEPTH_CODE + 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  input  logic       tx_pop,
  input  logic       rx_push,
  input  logic [7:0] rx_byte,
  output logic       tx_req,
  output logic       rx_req,
  output logic       err_req
);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic [TX_CW-1:0] tx_count;
  logic [RX_CW-1:0] rx_count;
  logic             tx_empty, rx_empty, tx_full, rx_full;
  logic [7:0]       rx_head, rx_last, tx_last;
  logic             tx_drop, rx_drop, rx_miss, tx_miss, rx_drop_unused;
  logic             tx_flush, rx_flush, tx_push, rx_pop;
  logic             tx_fifo_en, rx_fifo_en;
  logic [2:0]       stat_q;
  logic             tx_unused;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  uart_byte_fifo #(.DEPTH_CODE(TX_DEPTH_CODE), .W(8)) u_txq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flush     (tx_flush),
    .single    (~tx_fifo_en),
    .push      (tx_push),
    .push_data (reg_wdata),
    .pop       (tx_pop),
    .head      (tx_byte),
    .last      (tx_last),
    .count     (tx_count),
    .empty     (tx_empty),
    .full      (tx_full),
    .push_drop (tx_drop),
    .pop_miss  (tx_miss)
  );

  uart_byte_fifo #(.DEPTH_CODE(RX_DEPTH_CODE), .W(8)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .flush     (rx_flush),
    .single    (~rx_fifo_en),
    .push      (rx_push),
    .push_data (rx_byte),
    .pop       (rx_pop),
    .head      (rx_head),
    .last      (rx_last),
    .count     (rx_count),
    .empty     (rx_empty),
    .full      (rx_full),
    .push_drop (rx_drop),
    .pop_miss  (rx_miss)
  );

  uart_fifo_csr #(
    .TX_DEPTH_CODE (TX_DEPTH_CODE),
    .RX_DEPTH_CODE (RX_DEPTH_CODE),
    .TX_CW         (TX_CW),
    .RX_CW         (RX_CW)
  ) u_csr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .tx_count   (tx_count),
    .rx_count   (rx_count),
    .tx_empty   (tx_empty),
    .rx_empty   (rx_empty),
    .rx_head    (rx_head),
    .rx_last    (rx_last),
    .tx_drop    (tx_drop),
    .rx_drop    (rx_drop),
    .rx_miss    (rx_miss),
    .tx_flush   (tx_flush),
    .rx_flush   (rx_flush),
    .tx_push    (tx_push),
    .rx_pop     (rx_pop),
    .tx_fifo_en (tx_fifo_en),
    .rx_fifo_en (rx_fifo_en),
    .stat_q     (stat_q),
    .tx_req     (tx_req),
    .rx_req     (rx_req),
    .err_req    (err_req)
  );

  assign tx_valid       = ~tx_empty;
  assign tx_unused      = ^{tx_last, tx_miss, tx_full};
  assign rx_drop_unused = rx_full;

endmodule

// File: rtl/uart_fifo_chk.sv
module uart_fifo_chk #(
  parameter  int TX_DEPTH_CODE = 2,
  parameter  int RX_DEPTH_CODE = 1,
  localparam int TX_CW         = TX_DEPTH_CODE + 2,
  localparam int RX_CW         = RX_DEPTH_CODE + 2,
  localparam int TX_DEPTH      = 2 ** (TX_DEPTH_CODE + 1),
  localparam int RX_DEPTH      = 2 ** (RX_DEPTH_CODE + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [7:0]       reg_wdata,
  input logic             tx_req,
  input logic             rx_req,
  input logic             err_req,
  input logic [TX_CW-1:0] tx_count,
  input logic [RX_CW-1:0] rx_count,
  input logic             tx_fifo_en,
  input logic [2:0]       stat_q
);

  logic wr_ctrl, wr_stat, wr_size;
  assign wr_ctrl = reg_wr && (reg_addr == 3'd1);
  assign wr_stat = reg_wr && (reg_addr == 3'd2);
  assign wr_size = reg_wr && (reg_addr == 3'd0);

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= TX_CW'(TX_DEPTH)); // R3

  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= RX_CW'(RX_DEPTH)); // R8

  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_fifo_en && tx_count <= TX_CW'(1) && !(wr_size && reg_wdata[7]))
      |=> (tx_count <= TX_CW'(1))); // R2

  AST_FLUSH_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[7]) |=> (tx_count == '0)); // R5

  AST_FLUSH_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[6]) |=> (rx_count == '0)); // R5

  AST_FLUSH_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && (reg_wdata[7:6] != 2'b00))
      |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R5

  AST_TXOVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[1] && !(wr_stat && reg_wdata[1])) |=> stat_q[1]); // R3

  AST_EMPTY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0) |-> tx_req); // R6

  AST_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> !rx_req); // R7

  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    err_req |-> (stat_q != 3'b000)); // R11

endmodule

bind uart_fifo_regs uart_fifo_chk #(
  .TX_DEPTH_CODE (TX_DEPTH_CODE),
  .RX_DEPTH_CODE (RX_DEPTH_CODE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .tx_req     (tx_req),
  .rx_req     (rx_req),
  .err_req    (err_req),
  .tx_count   (tx_count),
  .rx_count   (rx_count),
  .tx_fifo_en (tx_fifo_en),
  .stat_q     (stat_q)
);

// File: tb/sim_uart_fifo_regs.sv
`timescale 1ns/1ps
module sim_uart_fifo_regs;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic       tx_pop = 1'b0;
  logic       rx_push = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       tx_req, rx_req, err_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_fifo_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_byte(rx_byte),
    .tx_req(tx_req), .rx_req(rx_req), .err_req(err_req)
  );

  typedef struct packed {
    logic       wr;
    logic [2:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 8'h00, 8'h21, 4'd1},  // R1 size codes after reset
    '{1'b0, 3'd2, 8'h00, 8'hC0, 4'd10}, // R10 both empty
    '{1'b1, 3'd7, 8'h11, 8'h00, 4'd2},
    '{1'b0, 3'd4, 8'h00, 8'h01, 4'd4},  // R4 one byte queued
    '{1'b1, 3'd7, 8'h22, 8'h00, 4'd2},  // single mode: dropped
    '{1'b0, 3'd2, 8'h00, 8'h42, 4'd2},  // R2 overflow flag
    '{1'b0, 3'd4, 8'h00, 8'h01, 4'd2},  // R2 count stays 1
    '{1'b1, 3'd2, 8'h02, 8'h00, 4'd10},
    '{1'b0, 3'd2, 8'h00, 8'h40, 4'd10}, // R10 W1C cleared
    '{1'b1, 3'd0, 8'hFF, 8'h00, 4'd1},
    '{1'b0, 3'd0, 8'h00, 8'hA9, 4'd1},  // R1 only enables writable
    '{1'b1, 3'd1, 8'h80, 8'h00, 4'd5},
    '{1'b0, 3'd4, 8'h00, 8'h00, 4'd5},  // R5 flushed
    '{1'b0, 3'd1, 8'h00, 8'h00, 4'd5}   // R5 flush bits read 0
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] d);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = d;
    @(posedge clk); #1;
    rx_push = 1'b0;
  endtask

  task automatic pop_tx();
    @(negedge clk);
    tx_pop = 1'b1;
    @(posedge clk); #1;
    tx_pop = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    do_reset();
    @(negedge clk);
    check("R12 reset tx_valid", {7'd0, tx_valid}, 8'h00);
    check("R6 reset tx_req", {7'd0, tx_req}, 8'h01);
    check("R7 reset rx_req", {7'd0, rx_req}, 8'h00);
    check("R11 reset err_req", {7'd0, err_req}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, v);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
      end
    end

    // R3 fill transmit queue to depth 8
    for (int i = 0; i < 8; i++) wr(3'd7, 8'hA0 + 8'(i));
    rd(3'd4, v); check("R3 R4 tx count full", v, 8'h08);
    @(negedge clk); check("R6 tx_req above mark", {7'd0, tx_req}, 8'h00);
    wr(3'd3, 8'h08);
    @(negedge clk); check("R6 tx_req at mark", {7'd0, tx_req}, 8'h01);
    wr(3'd7, 8'hFF);
    rd(3'd4, v); check("R3 count after drop", v, 8'h08);
    rd(3'd2, v); check("R3 tx overflow flag", v, 8'h42);

    // R12 drain in order
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R12 tx_valid", {7'd0, tx_valid}, 8'h01);
      check("R12 tx_byte order", tx_byte, 8'hA0 + 8'(i));
      pop_tx();
    end
    @(negedge clk); check("R12 drained", {7'd0, tx_valid}, 8'h00);

    // R6 threshold at mark 2
    wr(3'd3, 8'h02);
    wr(3'd7, 8'h01); wr(3'd7, 8'h02);
    @(negedge clk); check("R6 count 2 mark 2", {7'd0, tx_req}, 8'h01);
    wr(3'd7, 8'h03);
    @(negedge clk); check("R6 count 3 mark 2", {7'd0, tx_req}, 8'h00);

    // R5 flush keeps flag
    wr(3'd1, 8'h80);
    rd(3'd2, v); check("R5 flush keeps tx overflow", v, 8'hC2);
    wr(3'd2, 8'h00);
    rd(3'd2, v); check("R10 write 0 keeps flag", v, 8'hC2);
    wr(3'd2, 8'h02);

    // receive path, depth 4, mark 1
    wr(3'd5, 8'h01);
    push_rx(8'h31);
    @(negedge clk); check("R7 count 1 mark 1", {7'd0, rx_req}, 8'h00);
    push_rx(8'h32);
    @(negedge clk); check("R7 count 2 mark 1", {7'd0, rx_req}, 8'h01);
    push_rx(8'h33); push_rx(8'h34);
    rd(3'd6, v); check("R4 rx count", v, 8'h04);
    push_rx(8'h35);
    rd(3'd6, v); check("R8 rx count after drop", v, 8'h04);
    rd(3'd2, v); check("R8 rx overflow flag", v, 8'h84);
    for (int i = 0; i < 4; i++) begin
      rd(3'd7, v); check("R8 rx order", v, 8'h31 + 8'(i));
    end
    rd(3'd7, v); check("R9 underflow returns last", v, 8'h34);
    rd(3'd2, v); check("R9 underflow flag", v, 8'hC5);

    // R11 error request routing
    @(negedge clk); check("R11 disabled", {7'd0, err_req}, 8'h00);
    wr(3'd1, 8'h01);
    @(negedge clk); check("R11 underflow enabled", {7'd0, err_req}, 8'h01);
    rd(3'd1, v); check("R11 enables read back", v, 8'h01);
    wr(3'd2, 8'h07);
    @(negedge clk); check("R11 cleared", {7'd0, err_req}, 8'h00);
    rd(3'd2, v); check("R10 all flags cleared", v, 8'hC0);

    // R5 receive flush
    push_rx(8'h41); push_rx(8'h42);
    wr(3'd1, 8'h40);
    rd(3'd6, v); check("R5 rx flushed", v, 8'h00);

    // R2 back to single mode on receive
    wr(3'd0, 8'h80);
    push_rx(8'h51); push_rx(8'h52);
    rd(3'd6, v); check("R2 rx single holds one", v, 8'h01);
    rd(3'd2, v); check("R2 rx single overflow", v, 8'h84);

    // R1 reset with data queued
    wr(3'd7, 8'h77);
    do_reset();
    rd(3'd0, v); check("R1 size after reset", v, 8'h21);
    rd(3'd2, v); check("R10 status after reset", v, 8'hC0);
    rd(3'd4, v); check("R4 tx count after reset", v, 8'h00);

    finish_run();
  end

endmodule